// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits at the address front end of a synchronous burst memory. On a clock edge where an address strobe is recognised and all three chip enables are active, it captures the external address and starts a burst of up to four beats. Each later edge with the advance input low steps a two-bit beat counter. The block then produces the word address for the next beat, in either linear or interleaved order, as picked by a static order strap.

Two strobes can start an access: one driven by a processor and one driven by a memory controller. The processor strobe has priority when both are asserted. It is gated off entirely while the first chip enable is inactive, and the controller strobe still works in that case. The chip enables are looked at only on edges where a strobe is recognised. A recognised strobe with any enable inactive deselects the block, and no beat is produced until a later valid load.

The control core is a two-state machine. `ST_DESEL` is the reset state. `T_LOAD` moves from either state to `ST_SEL` on a strobe with all enables active. `T_DROP` moves from either state to `ST_DESEL` on a strobe with any enable inactive. `T_STEP` keeps `ST_SEL` and advances the beat counter when the advance input is low and no strobe is recognised. `T_HOLD` keeps the current state on every other edge.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where a strobe is recognised (`proc_stb_n`=0 with `cen_a_n`=0, or `ctrl_stb_n`=0) and `cen_a_n`=0, `cen_b`=1, `cen_c_n`=0, the next cycle shows `word_addr` equal to the sampled `addr_in` and `dev_sel`=1.
- R2: After a load the beat counter restarts, so the first beat's low two address bits equal the low two bits of the loaded address.
- R3: With both strobes low on the same edge, exactly one load takes place, and it uses the address on `addr_in`.
- R4: While `cen_a_n`=1, `proc_stb_n` has no effect: with `ctrl_stb_n`=1 and `adv_n`=1, both `word_addr` and `dev_sel` hold. A `ctrl_stb_n` low edge is still acted on in that case.
- R5: The chip enables are sampled only on edges with a recognised strobe. Changing them on other edges leaves `dev_sel` unchanged.
- R6: On an edge with `adv_n`=0, `dev_sel`=1 and no recognised strobe, the beat advances by one. A recognised strobe on the same edge takes precedence over `adv_n`. While `dev_sel`=0, `adv_n` leaves `word_addr` unchanged.
- R7: With `order_ilv`=0 (linear), the low two bits of `word_addr` equal (start offset + beat) mod 4.
- R8: With `order_ilv`=1 (interleaved), the low two bits of `word_addr` equal start offset XOR beat.
- R9: The fifth beat of a burst wraps back to the start offset. Bits above bit 1 of `word_addr` never change during a burst.
- R10: A recognised strobe with any chip enable inactive clears `dev_sel` on the next cycle and leaves `word_addr` unchanged.
- R11: While `rst_n`=0, `dev_sel`=0 and `word_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External word address |
| proc_stb_n | input | 1 | Processor address strobe, active low, gated by `cen_a_n` |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| cen_a_n | input | 1 | Chip enable A, active low |
| cen_b | input | 1 | Chip enable B, active high |
| cen_c_n | input | 1 | Chip enable C, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_ilv | input | 1 | Burst order strap: 0 selects linear, 1 selects interleaved |
| word_addr | output | ADDR_W | Address of the current beat |
| dev_sel | output | 1 | Registered device-selected flag |

## Verification
The bench walks every start offset in both orders through a full burst and one beat past it. A design that wraps wrongly, or that mixes up sum and XOR, shows the wrong low bits on some beat. Directed tests cover the processor strobe while `cen_a_n` is high: a design that fails to gate it would reload the address or change `dev_sel`. They also cover the controller strobe in the same condition, which must still deselect the block. Further tests change the enables between strobes, which must leave `dev_sel` alone, and assert advance together with a new load, where an ordering bug shows up as a beat offset of one. Advance pulses while deselected must not move the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_SEL   = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } strobe_src_e;

    typedef enum logic [2:0] {
        T_HOLD = 3'd0,
        T_LOAD = 3'd1,
        T_DROP = 3'd2,
        T_STEP = 3'd3
    } seq_trans_e;

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
    import burst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        proc_stb_n,
    input  logic        ctrl_stb_n,
    input  logic        cen_a_n,
    input  logic        cen_b,
    input  logic        cen_c_n,
    output strobe_src_e src,
    output logic        strobe_seen,
    output logic        enables_ok
);

    logic proc_gated;

    // The processor strobe only counts while enable A is active.
    assign proc_gated = ~proc_stb_n & ~cen_a_n;
    assign enables_ok = ~cen_a_n & cen_b & ~cen_c_n;

    always_comb begin
        if (proc_gated) begin
            src = SRC_PROC;
        end else if (!ctrl_stb_n) begin
            src = SRC_CTRL;
        end else begin
            src = SRC_NONE;
        end
    end

    assign strobe_seen = (src != SRC_NONE);

    // R4: with enable A inactive, only the controller strobe can be recognised.
    p_proc_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_a_n && ctrl_stb_n) |-> !strobe_seen);

    // R3: processor strobe wins when both are low.
    p_proc_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && !ctrl_stb_n && !cen_a_n) |-> (src == SRC_PROC));

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (restart) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + 1'b1;
        end
    end

    // R2: a restart returns the counter to beat zero.
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (beat == '0));

    // R6: a step without restart advances by exactly one (wrapping).
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart) |=> (beat == $past(beat) + 1'b1));

endmodule

// File: rtl/order_map.sv
module order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_ofs,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low_bits
);

    logic [BEAT_W-1:0] lin_bits;
    logic [BEAT_W-1:0] ilv_bits;

    assign lin_bits = start_ofs + beat;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_bits[i] = start_ofs[i] ^ beat[i];
    end

    assign low_bits = interleave ? ilv_bits : lin_bits;

    // R7/R8: at beat zero both orders give the start offset.
    always_comb begin
        if (beat == '0) begin
            a_beat0_start_r7: assert (low_bits == start_ofs);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              cen_a_n,
    input  logic              cen_b,
    input  logic              cen_c_n,
    input  logic              adv_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] word_addr,
    output logic              dev_sel
);

    localparam int HI_W = ADDR_W - BEAT_W;

    seq_state_e        state_q;
    seq_state_e        state_d;
    seq_trans_e        trans;
    strobe_src_e       src;
    logic              strobe_seen;
    logic              enables_ok;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_bits;
    logic              do_load;
    logic              do_step;

    strobe_decode u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_stb_n  (proc_stb_n),
        .ctrl_stb_n  (ctrl_stb_n),
        .cen_a_n     (cen_a_n),
        .cen_b       (cen_b),
        .cen_c_n     (cen_c_n),
        .src         (src),
        .strobe_seen (strobe_seen),
        .enables_ok  (enables_ok)
    );

    // Transition selection; a recognised strobe outranks advance.
    always_comb begin
        if (strobe_seen && enables_ok) begin
            trans = T_LOAD;
        end else if (strobe_seen) begin
            trans = T_DROP;
        end else if (!adv_n && state_q == ST_SEL) begin
            trans = T_STEP;
        end else begin
            trans = T_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (trans)
            T_LOAD:  state_d = ST_SEL;
            T_DROP:  state_d = ST_DESEL;
            T_STEP:  state_d = ST_SEL;
            T_HOLD:  state_d = state_q;
            default: state_d = state_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Address register: loads only on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (trans == T_LOAD) begin
            base_q <= addr_in;
        end
    end

    assign do_load = (trans == T_LOAD);
    assign do_step = (trans == T_STEP);

    beat_counter #(.BEAT_W(BEAT_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_load),
        .step    (do_step),
        .beat    (beat)
    );

    order_map #(.BEAT_W(BEAT_W)) u_order (
        .start_ofs  (base_q[BEAT_W-1:0]),
        .beat       (beat),
        .interleave (order_ilv),
        .low_bits   (low_bits)
    );

    // Output process.
    always_comb begin
        unique case (state_q)
            ST_SEL:   dev_sel = 1'b1;
            ST_DESEL: dev_sel = 1'b0;
            default:  dev_sel = 1'b0;
        endcase
        word_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};
    end

    // R1: a valid strobe captures the bus and selects the device.
    p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_seen && enables_ok) |=> (word_addr == $past(addr_in) && dev_sel));

    // R10: a strobe with an inactive enable deselects and keeps the address.
    p_drop_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_seen && !enables_ok) |=> (!dev_sel && $stable(word_addr)));

    // R5: without a recognised strobe the selected flag holds.
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_seen |=> $stable(dev_sel));

    // R9: upper address bits only change on a load.
    p_hi_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_seen && enables_ok) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

    // R6: advance while deselected does not move the address.
    p_desel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_sel && !strobe_seen) |=> $stable(word_addr));

    // R11: reset leaves the block deselected.
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!dev_sel && word_addr == '0));

    initial begin
        a_width_ok: assert (HI_W > 0);
    end

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              proc_stb_n = 1'b1;
    logic              ctrl_stb_n = 1'b1;
    logic              cen_a_n = 1'b1;
    logic              cen_b = 1'b0;
    logic              cen_c_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              order_ilv = 1'b1;
    logic [ADDR_W-1:0] word_addr;
    logic              dev_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_in    (addr_in),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .cen_a_n    (cen_a_n),
        .cen_b      (cen_b),
        .cen_c_n    (cen_c_n),
        .adv_n      (adv_n),
        .order_ilv  (order_ilv),
        .word_addr  (word_addr),
        .dev_sel    (dev_sel)
    );

    // {interleave, start offset, beats 0..3 packed two bits each, beat 0 first}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 2'd0, 8'h1B},
        {1'b0, 2'd1, 8'h6C},
        {1'b0, 2'd2, 8'hB1},
        {1'b0, 2'd3, 8'hC6},
        {1'b1, 2'd0, 8'h1B},
        {1'b1, 2'd1, 8'h4E},
        {1'b1, 2'd2, 8'hB1},
        {1'b1, 2'd3, 8'hE4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enables(input logic ok);
        cen_a_n = ~ok;
        cen_b   = ok;
        cen_c_n = ~ok;
    endtask

    task automatic quiet();
        proc_stb_n = 1'b1;
        ctrl_stb_n = 1'b1;
        adv_n      = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) tick();
        chk("R11 dev_sel in reset", dev_sel, 0);
        chk("R11 word_addr in reset", word_addr, 0);
        rst_n = 1'b1;
        tick();

        // R7 R8 R2 R9: every offset in both orders
        for (int v = 0; v < 8; v++) begin
            logic [ADDR_W-1:0] hi_part;
            hi_part = ADDR_W'((12'h50 + v * 7) << 2);
            order_ilv = VEC[v][10];
            enables(1'b1);
            addr_in = hi_part | ADDR_W'(VEC[v][9:8]);
            if (v % 2 == 0) ctrl_stb_n = 1'b0; else proc_stb_n = 1'b0;
            tick();
            quiet();
            enables(1'b0);
            addr_in = '1;
            chk("R2 beat0 offset", word_addr, hi_part | ADDR_W'(VEC[v][7:6]));
            chk("R1 selected after load", dev_sel, 1);
            for (int b = 1; b < 4; b++) begin
                adv_n = 1'b0;
                tick();
                if (VEC[v][10])
                    chk("R8 interleaved beat", word_addr, hi_part | ADDR_W'(VEC[v][7 - 2*b -: 2]));
                else
                    chk("R7 linear beat", word_addr, hi_part | ADDR_W'(VEC[v][7 - 2*b -: 2]));
            end
            tick();
            chk("R9 wrap to start", word_addr, hi_part | ADDR_W'(VEC[v][9:8]));
            adv_n = 1'b1;
        end

        // R3: both strobes together, single load from the bus
        order_ilv = 1'b0;
        enables(1'b1);
        addr_in = 12'h3A5;
        proc_stb_n = 1'b0;
        ctrl_stb_n = 1'b0;
        tick();
        quiet();
        chk("R3 both strobes load", word_addr, 12'h3A5);
        chk("R3 selected", dev_sel, 1);

        // R4: processor strobe ignored with enable A inactive
        cen_a_n = 1'b1;
        addr_in = 12'h111;
        proc_stb_n = 1'b0;
        tick();
        chk("R4 proc ignored addr", word_addr, 12'h3A5);
        chk("R4 proc ignored sel", dev_sel, 1);
        // R4/R10: controller strobe still acts and deselects
        proc_stb_n = 1'b1;
        ctrl_stb_n = 1'b0;
        tick();
        quiet();
        chk("R10 ctrl strobe deselects", dev_sel, 0);
        chk("R10 address held on drop", word_addr, 12'h3A5);

        // R6: advance while deselected holds the address
        adv_n = 1'b0;
        tick();
        tick();
        adv_n = 1'b1;
        chk("R6 no advance when deselected", word_addr, 12'h3A5);

        // R5: enables toggle without a strobe, flag holds
        enables(1'b1);
        tick();
        chk("R5 desel holds", dev_sel, 0);
        addr_in = 12'h0C8;
        ctrl_stb_n = 1'b0;
        tick();
        ctrl_stb_n = 1'b1;
        chk("R1 ctrl load", word_addr, 12'h0C8);
        enables(1'b0);
        tick();
        chk("R5 sel holds", dev_sel, 1);

        // R6: load outranks advance on the same edge
        enables(1'b1);
        adv_n = 1'b0;
        tick();
        chk("R6 step linear", word_addr, 12'h0C9);
        addr_in = 12'h2F2;
        ctrl_stb_n = 1'b0;
        tick();
        ctrl_stb_n = 1'b1;
        chk("R6 load wins over advance", word_addr, 12'h2F2);
        tick();
        chk("R6 step after load", word_addr, 12'h2F3);
        adv_n = 1'b1;

        // R10: strobe with enable B inactive drops, address kept
        cen_b = 1'b0;
        addr_in = 12'h777;
        proc_stb_n = 1'b0;
        tick();
        quiet();
        chk("R10 enable B drop", dev_sel, 0);
        chk("R10 address unchanged", word_addr, 12'h2F3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule